// File: doc/BRIEF.md
# Protection Pass-Switch Mode and Lockout Controller

This block is the digital controller of a bidirectional protection pass switch that sits between an external adapter input and the system supply rail. A two-bit mode selection picks one of four operating modes. The block receives five analog comparator results as plain digital inputs: input under the low limit, input over the normal high limit, input over the raised high limit, negative input and overtemperature. Each one passes through a two-flop synchroniser before the logic uses it.

In the two forward modes the switch closes only after the input has stayed inside its valid window for a full turn-on delay. The active-low fault output is released after a second delay that starts when the switch closes. Any window fault, negative input or overtemperature opens the switch and asserts the fault output at once. A fault also clears both delay counters, so a recovery always waits the full delays again. In the disable mode the switch stays open, but the fault output still reports the input window directly. In the reverse mode the window comparators are ignored and the switch is held closed, unless overtemperature or a negative input is present. Current limiting in reverse mode belongs to a separate sequencer. Both delays are counted in milliseconds, based on a clocks-per-millisecond parameter.

Top module: `pass_switch_ctrl`

## Requirements
- R1: `mode_sel` decodes as 2'b00 raised-limit forward mode, 2'b01 normal forward mode, 2'b10 reverse mode and 2'b11 disable mode.
- R2: In a forward mode, `pass_en` rises exactly TON_MS*CLKS_PER_MS+3 clock edges after the comparator inputs become valid (two synchroniser edges plus one register edge). A window is valid when not under, not over the selected high limit and not negative.
- R3: `fault_n` rises exactly TFLAG_MS*CLKS_PER_MS edges after `pass_en` rises in a forward mode. While in a forward mode, `fault_n` is never high with `pass_en` low.
- R4: In a forward mode, an under-limit or over-limit input drives `pass_en` low and `fault_n` low on the third clock edge after the input change, with no delay count.
- R5: Raised-limit forward mode compares against `cmp_over_hi` and ignores `cmp_over`; `hi_res_sel` is high only while the switch is closed in that mode.
- R6: In disable mode, `pass_en` stays low indefinitely and `fault_n` equals the window state (high inside, low outside) three edges after a comparator change, with no delay count.
- R7: In reverse mode, `cmp_under`, `cmp_over` and `cmp_over_hi` have no effect. `pass_en` and `fault_n` go high on the first edge after the mode is entered.
- R8: `cmp_hot` drives `pass_en` and `fault_n` low in every mode. When it clears, reverse and disable modes recover within three edges, and the forward modes restart the full turn-on delay.
- R9: `cmp_neg` drives `pass_en` low in every mode. In the forward modes it also counts as a window fault, so `fault_n` goes low.
- R10: A fault during the turn-on count or during the flag count clears both counters. Both delays then run in full again from the moment the input is valid again.
- R11: Any change of `mode_sel` restarts the sequence. Leaving normal forward mode opens the switch on the next edge, and re-entering a forward mode with a valid window closes the switch TON_MS*CLKS_PER_MS+2 edges after the change.
- R12: During and directly after reset, `pass_en`, `hi_res_sel` and `fault_n` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Operating mode selection (see R1) |
| cmp_under | input | 1 | Input below low limit |
| cmp_over | input | 1 | Input above normal high limit |
| cmp_over_hi | input | 1 | Input above raised high limit |
| cmp_neg | input | 1 | Input voltage negative |
| cmp_hot | input | 1 | Die temperature above shutdown limit |
| pass_en | output | 1 | Pass switch enable |
| hi_res_sel | output | 1 | Select high-resistance path |
| fault_n | output | 1 | Fault flag, active low |

## Verification
The bench samples at the exact edges on both sides of each delay boundary. A delay that is off by one cycle, or a prescaler that runs freely instead of restarting, therefore shows up as a wrong level at a named edge. Faults are injected partway through the turn-on count and again partway through the flag count. A design that kept its counters across a fault would close the switch or release the flag early. The raised-limit mode is driven with only the normal over-limit comparator set, which catches a design that picks the wrong comparator. The disable and reverse modes are driven with window faults and over-temperature. A design that applied the forward delays there, or let the window comparators act in reverse mode, would show the wrong flag or switch level.

// File: rtl/psw_pkg.sv
package psw_pkg;

    typedef enum logic [1:0] {
        MODE_RAISED = 2'b00,
        MODE_FWD    = 2'b01,
        MODE_BACK   = 2'b10,
        MODE_OFF    = 2'b11
    } op_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_SETTLE,
        ST_RUN
    } seq_state_t;

    typedef struct packed {
        logic under;
        logic over;
        logic over_hi;
        logic neg;
        logic hot;
    } cmp_vec_t;

    localparam int CMP_W = $bits(cmp_vec_t);

    function automatic logic is_forward(op_mode_t m);
        return (m == MODE_RAISED) || (m == MODE_FWD);
    endfunction

endpackage

// File: rtl/psw_sync.sv
module psw_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/psw_window.sv
module psw_window
    import psw_pkg::*;
(
    input  op_mode_t mode,
    input  logic     under,
    input  logic     over,
    input  logic     over_hi,
    input  logic     neg,
    output logic     win_ok
);
    logic sel_over;

    // raised-limit mode looks at the higher comparator (R5)
    always_comb begin
        sel_over = (mode == MODE_RAISED) ? over_hi : over;
        win_ok   = !under && !sel_over && !neg;
    end
endmodule

// File: rtl/psw_seq.sv
module psw_seq
    import psw_pkg::*;
#(
    parameter int CLKS_PER_MS = 125000,
    parameter int TON_MS      = 30,
    parameter int TFLAG_MS    = 30
) (
    input  logic     clk,
    input  logic     rst,
    input  op_mode_t mode,
    input  logic     win_ok,
    input  logic     hot,
    input  logic     neg,
    output logic     sw_o,
    output logic     flag_o,
    output logic     hr_o
);
    localparam int PRE_W  = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam int MS_MAX = (TON_MS > TFLAG_MS) ? TON_MS : TFLAG_MS;
    localparam int MS_W   = (MS_MAX > 0) ? $clog2(MS_MAX + 1) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST  = PRE_W'(CLKS_PER_MS - 1);
    localparam logic [MS_W-1:0]  ARM_LAST  = MS_W'(TON_MS - 1);
    localparam logic [MS_W-1:0]  FLAG_LAST = MS_W'(TFLAG_MS - 1);

    seq_state_t       st_q, st_d;
    op_mode_t         mode_prev;
    logic [PRE_W-1:0] pre_q, pre_d;
    logic [MS_W-1:0]  ms_q, ms_d;
    logic             sw_q, sw_d, flag_q, flag_d, hr_q, hr_d;
    logic             mode_chg;

    always_comb begin
        st_d     = st_q;
        pre_d    = pre_q;
        ms_d     = ms_q;
        sw_d     = 1'b0;
        flag_d   = 1'b0;
        hr_d     = 1'b0;
        mode_chg = (mode != mode_prev);
        unique case (mode)
            MODE_RAISED, MODE_FWD: begin
                if (!win_ok || hot || mode_chg) begin
                    st_d  = ST_IDLE;
                    pre_d = '0;
                    ms_d  = '0;
                end else begin
                    unique case (st_q)
                        ST_IDLE: begin
                            st_d  = ST_ARM;
                            pre_d = '0;
                            ms_d  = '0;
                        end
                        ST_ARM: begin
                            if (pre_q == PRE_LAST) begin
                                pre_d = '0;
                                if (ms_q == ARM_LAST) begin
                                    st_d = ST_SETTLE;
                                    ms_d = '0;
                                end else begin
                                    ms_d = ms_q + 1'b1;
                                end
                            end else begin
                                pre_d = pre_q + 1'b1;
                            end
                        end
                        ST_SETTLE: begin
                            if (pre_q == PRE_LAST) begin
                                pre_d = '0;
                                if (ms_q == FLAG_LAST) begin
                                    st_d = ST_RUN;
                                    ms_d = '0;
                                end else begin
                                    ms_d = ms_q + 1'b1;
                                end
                            end else begin
                                pre_d = pre_q + 1'b1;
                            end
                        end
                        default: st_d = ST_RUN;
                    endcase
                end
                sw_d   = (st_d == ST_SETTLE) || (st_d == ST_RUN);
                flag_d = (st_d == ST_RUN);
                hr_d   = sw_d && (mode == MODE_RAISED);
            end
            MODE_OFF: begin
                st_d   = ST_IDLE;
                pre_d  = '0;
                ms_d   = '0;
                flag_d = win_ok && !hot;
            end
            default: begin
                st_d   = ST_IDLE;
                pre_d  = '0;
                ms_d   = '0;
                sw_d   = !hot && !neg;
                flag_d = !hot;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            mode_prev <= MODE_OFF;
            pre_q     <= '0;
            ms_q      <= '0;
            sw_q      <= 1'b0;
            flag_q    <= 1'b0;
            hr_q      <= 1'b0;
        end else begin
            st_q      <= st_d;
            mode_prev <= mode;
            pre_q     <= pre_d;
            ms_q      <= ms_d;
            sw_q      <= sw_d;
            flag_q    <= flag_d;
            hr_q      <= hr_d;
        end
    end

    assign sw_o   = sw_q;
    assign flag_o = flag_q;
    assign hr_o   = hr_q;

    p_window_fault_r4: assert property (@(posedge clk) disable iff (rst)
        is_forward(mode) && !win_ok |=> !sw_q && !flag_q);
    p_hot_opens_r8: assert property (@(posedge clk) disable iff (rst)
        hot |=> !sw_q && !flag_q);
    p_neg_opens_r9: assert property (@(posedge clk) disable iff (rst)
        neg |=> !sw_q);
    p_off_open_r6: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_OFF |=> !sw_q);
    p_back_closed_r7: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_BACK && !hot && !neg |=> sw_q && flag_q);
    p_flag_after_sw_r3: assert property (@(posedge clk) disable iff (rst)
        is_forward(mode_prev) && flag_q |-> sw_q);
    p_hires_only_raised_r5: assert property (@(posedge clk) disable iff (rst)
        hr_q |-> sw_q && mode_prev == MODE_RAISED);
    p_close_from_arm_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_q) && is_forward(mode_prev) |-> $past(st_q) == ST_ARM);
    p_prescale_range_r2: assert property (@(posedge clk) disable iff (rst)
        pre_q <= PRE_LAST);
    p_mode_restart_r11: assert property (@(posedge clk) disable iff (rst)
        mode != mode_prev |=> st_q == ST_IDLE);
endmodule

// File: rtl/pass_switch_ctrl.sv
module pass_switch_ctrl
    import psw_pkg::*;
#(
    parameter int CLKS_PER_MS = 125000,
    parameter int TON_MS      = 30,
    parameter int TFLAG_MS    = 30,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    input  logic       cmp_under,
    input  logic       cmp_over,
    input  logic       cmp_over_hi,
    input  logic       cmp_neg,
    input  logic       cmp_hot,
    output logic       pass_en,
    output logic       hi_res_sel,
    output logic       fault_n
);
    cmp_vec_t         raw, cs;
    logic [CMP_W-1:0] cs_bits;
    op_mode_t         mode;
    logic             win_ok;

    assign raw  = '{under: cmp_under, over: cmp_over, over_hi: cmp_over_hi,
                    neg: cmp_neg, hot: cmp_hot};
    assign mode = op_mode_t'(mode_sel);
    assign cs   = cmp_vec_t'(cs_bits);

    psw_sync #(.WIDTH(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (cs_bits)
    );

    psw_window u_win (
        .mode    (mode),
        .under   (cs.under),
        .over    (cs.over),
        .over_hi (cs.over_hi),
        .neg     (cs.neg),
        .win_ok  (win_ok)
    );

    psw_seq #(
        .CLKS_PER_MS (CLKS_PER_MS),
        .TON_MS      (TON_MS),
        .TFLAG_MS    (TFLAG_MS)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .win_ok (win_ok),
        .hot    (cs.hot),
        .neg    (cs.neg),
        .sw_o   (pass_en),
        .flag_o (fault_n),
        .hr_o   (hi_res_sel)
    );
endmodule

// File: tb/sim_pass_switch_ctrl.sv
module sim_pass_switch_ctrl;
    localparam int K  = 4;
    localparam int TN = 3;
    localparam int TF = 2;
    localparam int N  = TN * K;
    localparam int M  = TF * K;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode_sel = 2'b01;
    logic u = 1'b1, o = 1'b0, oh = 1'b0, ng = 1'b0, ht = 1'b0;
    logic pass_en, hi_res_sel, fault_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic  sw;
        logic  fl;
        logic  hr;
        string tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    pass_switch_ctrl #(.CLKS_PER_MS(K), .TON_MS(TN), .TFLAG_MS(TF)) u0 (
        .clk(clk), .rst(rst), .mode_sel(mode_sel),
        .cmp_under(u), .cmp_over(o), .cmp_over_hi(oh),
        .cmp_neg(ng), .cmp_hot(ht),
        .pass_en(pass_en), .hi_res_sel(hi_res_sel), .fault_n(fault_n)
    );

    task automatic step(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input logic sw, input logic fl, input logic hr, input string tag);
        exp_t e;
        e.sw = sw; e.fl = fl; e.hr = hr; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares queued expectations just after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (pass_en !== e.sw || fault_n !== e.fl || hi_res_sel !== e.hr) begin
                    errors++;
                    $display("FAIL %s: got pass_en=%b fault_n=%b hi_res_sel=%b expected %b %b %b",
                             e.tag, pass_en, fault_n, hi_res_sel, e.sw, e.fl, e.hr);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(2);
        expect_out(0, 0, 0, "R12 in reset");
        rst = 1'b0;
        step(1);
        expect_out(0, 0, 0, "R12 after reset");

        // normal forward mode, window invalid then valid
        step(4);
        expect_out(0, 0, 0, "R2 invalid window stays open");
        u = 1'b0;
        step(N + 2);
        expect_out(0, 0, 0, "R2 one edge before close");
        step(1);
        expect_out(1, 0, 0, "R2 closes at delay end");
        step(M - 1);
        expect_out(1, 0, 0, "R3 flag held one edge before");
        step(1);
        expect_out(1, 1, 0, "R3 flag released");

        // over-limit fault, immediate
        o = 1'b1;
        step(2);
        expect_out(1, 1, 0, "R4 before sync delay");
        step(1);
        expect_out(0, 0, 0, "R4 over fault opens");
        o = 1'b0;
        step(N + 3);
        expect_out(1, 0, 0, "R4 recovery closes");
        step(M);
        expect_out(1, 1, 0, "R4 recovery flag");
        u = 1'b1;
        step(3);
        expect_out(0, 0, 0, "R4 under fault opens");

        // fault during turn-on count
        u = 1'b0;
        step(8);
        u = 1'b1;
        step(3);
        expect_out(0, 0, 0, "R10 fault in turn-on count");
        u = 1'b0;
        step(N + 2);
        expect_out(0, 0, 0, "R10 turn-on count restarted");
        step(1);
        expect_out(1, 0, 0, "R10 closes after full delay");
        // fault during flag count
        step(3);
        o = 1'b1;
        step(3);
        expect_out(0, 0, 0, "R10 fault in flag count");
        o = 1'b0;
        step(N + 2);
        expect_out(0, 0, 0, "R10 open before full delay");
        step(1);
        expect_out(1, 0, 0, "R10 closes again");
        step(M - 1);
        expect_out(1, 0, 0, "R10 flag count restarted");
        step(1);
        expect_out(1, 1, 0, "R10 flag released");

        // raised-limit forward mode: normal over comparator ignored
        mode_sel = 2'b00;
        o = 1'b1;
        step(1);
        expect_out(0, 0, 0, "R11 mode change restarts");
        step(N);
        expect_out(0, 0, 0, "R11 open before delay");
        step(1);
        expect_out(1, 0, 1, "R5 R1 raised mode closes on high path");
        step(M);
        expect_out(1, 1, 1, "R5 raised mode flag");
        oh = 1'b1;
        step(3);
        expect_out(0, 0, 0, "R5 raised comparator faults");
        oh = 1'b0;
        step(N + 3);
        expect_out(1, 0, 1, "R5 raised recovery");
        step(M);
        expect_out(1, 1, 1, "R5 raised recovery flag");

        // back to normal forward mode
        o = 1'b0;
        step(4);
        mode_sel = 2'b01;
        step(N + 1);
        expect_out(0, 0, 0, "R11 reentry open before delay");
        step(1);
        expect_out(1, 0, 0, "R11 reentry closes low path");
        step(M);
        expect_out(1, 1, 0, "R11 reentry flag");

        // disable mode
        mode_sel = 2'b11;
        step(1);
        expect_out(0, 1, 0, "R11 R1 leaving forward opens next edge");
        u = 1'b1;
        step(2);
        expect_out(0, 1, 0, "R6 flag before sync delay");
        step(1);
        expect_out(0, 0, 0, "R6 flag tracks under");
        u = 1'b0;
        step(3);
        expect_out(0, 1, 0, "R6 flag tracks valid without delay");
        o = 1'b1;
        step(3);
        expect_out(0, 0, 0, "R6 flag tracks over");
        o = 1'b0;
        step(N + M + 5);
        expect_out(0, 1, 0, "R6 switch stays open");

        // reverse mode
        mode_sel = 2'b10;
        u = 1'b1;
        o = 1'b1;
        step(1);
        expect_out(1, 1, 0, "R7 R1 reverse closes next edge");
        step(5);
        expect_out(1, 1, 0, "R7 window comparators ignored");
        ht = 1'b1;
        step(3);
        expect_out(0, 0, 0, "R8 hot in reverse");
        ht = 1'b0;
        step(3);
        expect_out(1, 1, 0, "R8 reverse resumes");
        ng = 1'b1;
        step(3);
        expect_out(0, 1, 0, "R9 negative in reverse");
        ng = 1'b0;
        step(3);
        expect_out(1, 1, 0, "R9 reverse resumes");

        // overtemperature and negative input in forward mode
        u = 1'b0;
        o = 1'b0;
        step(4);
        mode_sel = 2'b01;
        step(N + 1);
        expect_out(0, 0, 0, "R11 from reverse open before delay");
        step(1);
        expect_out(1, 0, 0, "R11 from reverse closes");
        step(M);
        expect_out(1, 1, 0, "R3 flag after reverse exit");
        ht = 1'b1;
        step(3);
        expect_out(0, 0, 0, "R8 hot in forward");
        ht = 1'b0;
        step(N + 2);
        expect_out(0, 0, 0, "R8 full delay after hot");
        step(1);
        expect_out(1, 0, 0, "R8 closes after hot");
        step(M);
        ng = 1'b1;
        step(3);
        expect_out(0, 0, 0, "R9 negative in forward");
        ng = 1'b0;
        step(N + 3);
        expect_out(1, 0, 0, "R9 forward recovery");

        // overtemperature in disable mode
        mode_sel = 2'b11;
        step(4);
        expect_out(0, 1, 0, "R6 disable valid window");
        ht = 1'b1;
        step(3);
        expect_out(0, 0, 0, "R8 hot in disable");
        ht = 1'b0;
        step(3);
        expect_out(0, 1, 0, "R8 disable recovers");

        step(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule